// File: doc/BRIEF.md
# Display Row Data Latch

This block holds one row of display memory, 132 bits wide by default, and drives the segment drivers from that held copy. On every clock edge where the display line strobe is high, the row currently read from display memory is captured into a register bank. The held row is then shaped by three mode flags before it leaves the block: a display-enable flag, an inverse flag and a static-drive flag.

The mode flags work only on the path from the register bank to the segment outputs. The block has no write path back to display memory, so blanking, inverting or forcing the panel never changes what memory holds. Capture runs on the display's own line strobe and does not take part in host access to memory. When a flag changes between strobes, the new output appears in the same cycle, built from the row already held.

Top module: `row_latch_top`

## Requirements
- R1: While `rst_n` is low, the held row is cleared to all zeros and any strobe is ignored. After release, with display enabled and no other mode, `seg_out` is all zeros until the first capture.
- R2: On a rising clock edge with `rst_n` high and `line_strobe` high, the block captures `row_data`. From that edge on, `seg_out` equals the captured row when `disp_on`=1, `static_drv`=0 and `inverse`=0.
- R3: On a rising edge with `line_strobe` low, the held row keeps its value. Changes on `row_data` have no effect on `seg_out` until the next strobe.
- R4: When `disp_on`=0, every bit of `seg_out` is 0, whatever `static_drv`, `inverse` and the held row are.
- R5: When `disp_on`=1 and `static_drv`=1, every bit of `seg_out` is 1, whatever `inverse` and the held row are.
- R6: When `disp_on`=1, `static_drv`=0 and `inverse`=1, `seg_out` is the bitwise complement of the held row.
- R7: A change of the mode flags alters `seg_out` in the same cycle, without a clock edge, and never alters the held row. Going back to normal mode shows the row captured last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_strobe | input | 1 | High for one or more cycles; each high edge captures a row |
| row_data | input | SEG_W (132) | Row read from display memory |
| disp_on | input | 1 | 1 = display enabled, 0 = all outputs blank |
| inverse | input | 1 | 1 = complement the held row at the output |
| static_drv | input | 1 | 1 = force all outputs to 1 (while enabled) |
| seg_out | output | SEG_W (132) | Segment pattern to the drivers |

## Verification
The hardest case to reach from the ports is showing that a mode change leaves the held row untouched. The output never shows the held row while a modifier is active. The stimulus therefore captures a known row, steps through every flag combination in the middle of a cycle with no strobe, checking the combinational output each time, and then returns to normal mode to compare against the row captured before the detour. Reset with the strobe held high and fresh data on `row_data` shows that capture is blocked while reset is asserted.

// File: rtl/row_latch_pkg.sv
// Package: shared types for the display row latch.
// Assumes: the view encoding is used inside the block only.
package row_latch_pkg;

    // Output view selected from the mode flags.
    typedef enum logic [1:0] {
        VIEW_BLANK  = 2'd0,
        VIEW_SOLID  = 2'd1,
        VIEW_INVERT = 2'd2,
        VIEW_TRUE   = 2'd3
    } view_e;

    // Resolve the flags by priority: blank first, then solid, then invert.
    function automatic view_e resolve_view(input logic on_f, input logic inv_f,
                                           input logic stat_f);
        view_e v;
        if (!on_f)       v = VIEW_BLANK;
        else if (stat_f) v = VIEW_SOLID;
        else if (inv_f)  v = VIEW_INVERT;
        else             v = VIEW_TRUE;
        return v;
    endfunction

endpackage

// File: rtl/row_capture.sv
// Module: row_capture
// Holds one display row in a register bank split into slices.
// A row is loaded on each clock edge where the strobe is high.
// Assumes: synchronous active-low reset clears the bank to zero.
module row_capture #(
    parameter int SEG_W   = 132,
    parameter int SLICE_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEG_W-1:0] din,
    output logic [SEG_W-1:0] held
);
    localparam int NUM_SLICES = (SEG_W + SLICE_W - 1) / SLICE_W;

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        localparam int LO = i * SLICE_W;
        localparam int HI = ((LO + SLICE_W) > SEG_W) ? (SEG_W - 1) : (LO + SLICE_W - 1);

        // Load or hold one slice of the row.
        always_ff @(posedge clk) begin
            if (!rst_n)
                held[HI:LO] <= '0;
            else if (load)
                held[HI:LO] <= din[HI:LO];
        end
    end
endmodule

// File: rtl/view_select.sv
// Module: view_select
// Turns the three mode flags into one view code by fixed priority.
// Assumes: flags are steady within a cycle; the path is combinational.
module view_select
    import row_latch_pkg::*;
(
    input  logic  disp_on,
    input  logic  inverse,
    input  logic  static_drv,
    output view_e view
);
    // Priority resolve of the mode flags.
    always_comb view = resolve_view(disp_on, inverse, static_drv);
endmodule

// File: rtl/seg_shaper.sv
// Module: seg_shaper
// Applies the selected view to the held row, slice by slice.
// Assumes: the held row is never written from here; output only.
module seg_shaper
    import row_latch_pkg::*;
#(
    parameter int SEG_W   = 132,
    parameter int SLICE_W = 33
) (
    input  logic [SEG_W-1:0] held,
    input  view_e            view,
    output logic [SEG_W-1:0] seg
);
    localparam int NUM_SLICES = (SEG_W + SLICE_W - 1) / SLICE_W;

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        localparam int LO = i * SLICE_W;
        localparam int HI = ((LO + SLICE_W) > SEG_W) ? (SEG_W - 1) : (LO + SLICE_W - 1);

        // Shape one slice according to the view.
        always_comb begin
            unique case (view)
                VIEW_BLANK:  seg[HI:LO] = '0;
                VIEW_SOLID:  seg[HI:LO] = '1;
                VIEW_INVERT: seg[HI:LO] = ~held[HI:LO];
                default:     seg[HI:LO] = held[HI:LO];
            endcase
        end
    end
endmodule

// File: rtl/row_latch_top.sv
// Module: row_latch_top
// Display row latch: captures a memory row on the line strobe and shapes
// it by display-enable, inverse and static-drive flags.
// Assumes: strobe is synchronous to clk; no path back to display memory.
module row_latch_top
    import row_latch_pkg::*;
#(
    parameter int SEG_W   = 132,
    parameter int SLICE_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_strobe,
    input  logic [SEG_W-1:0] row_data,
    input  logic             disp_on,
    input  logic             inverse,
    input  logic             static_drv,
    output logic [SEG_W-1:0] seg_out
);
    logic [SEG_W-1:0] held_row;
    view_e            cur_view;

    row_capture #(.SEG_W(SEG_W), .SLICE_W(SLICE_W)) u_cap (
        .clk  (clk),
        .rst_n(rst_n),
        .load (line_strobe),
        .din  (row_data),
        .held (held_row)
    );

    view_select u_view (
        .disp_on   (disp_on),
        .inverse   (inverse),
        .static_drv(static_drv),
        .view      (cur_view)
    );

    seg_shaper #(.SEG_W(SEG_W), .SLICE_W(SLICE_W)) u_shape (
        .held(held_row),
        .view(cur_view),
        .seg (seg_out)
    );
endmodule

// File: rtl/row_latch_chk.sv
// Module: row_latch_chk
// Port-level properties of the display row latch, bound to the top.
// Assumes: reset is held low from time zero until the first edges.
module row_latch_chk #(
    parameter int SEG_W = 132
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_strobe,
    input logic [SEG_W-1:0] row_data,
    input logic             disp_on,
    input logic             inverse,
    input logic             static_drv,
    input logic [SEG_W-1:0] seg_out
);
    logic plain;
    assign plain = disp_on && !static_drv && !inverse;

    AST_BLANK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |-> (seg_out == '0)); // R4

    AST_SOLID_WHEN_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_on && static_drv) |-> (&seg_out)); // R5

    AST_CAPTURE_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(line_strobe) && plain) |-> (seg_out == $past(row_data))); // R2

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(line_strobe) && plain && $past(plain)) |-> $stable(seg_out)); // R3

    AST_INVERT_OF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(line_strobe) && $past(plain) && disp_on && !static_drv && inverse)
        |-> (seg_out == ~$past(seg_out))); // R6
endmodule

bind row_latch_top row_latch_chk #(.SEG_W(SEG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_strobe(line_strobe),
    .row_data   (row_data),
    .disp_on    (disp_on),
    .inverse    (inverse),
    .static_drv (static_drv),
    .seg_out    (seg_out)
);

// File: tb/sim_row_latch_top.sv
module sim_row_latch_top;
    localparam int W = 132;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_strobe = 1'b0;
    logic [W-1:0] row_data = '0;
    logic         disp_on = 1'b1;
    logic         inverse = 1'b0;
    logic         static_drv = 1'b0;
    logic [W-1:0] seg_out;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [W-1:0] hist[$];
    logic [W-1:0] saved;

    always #4 clk = ~clk;

    row_latch_top u0 (
        .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .row_data(row_data),
        .disp_on(disp_on), .inverse(inverse), .static_drv(static_drv), .seg_out(seg_out)
    );

    // Behavioural model: queue of captured rows, cleared by reset.
    always @(posedge clk) begin
        if (!rst_n) hist.delete();
        else if (line_strobe) hist.push_back(row_data);
    end

    function automatic logic [W-1:0] model_row();
        return (hist.size() == 0) ? '0 : hist[hist.size()-1];
    endfunction

    function automatic logic [W-1:0] model_out();
        if (!disp_on) return '0;
        if (static_drv) return '1;
        if (inverse) return ~model_row();
        return model_row();
    endfunction

    function automatic string mode_tag();
        if (!disp_on) return "R4";
        if (static_drv) return "R5";
        if (inverse) return "R6";
        return (hist.size() == 0) ? "R1" : "R2/R3";
    endfunction

    task automatic check_now(input string tag);
        logic [W-1:0] exp_v;
        exp_v = model_out();
        n_checks++;
        if (seg_out !== exp_v) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, seg_out, exp_v);
        end
    endtask

    // Compare against the model on every clock, away from the edge.
    always @(negedge clk) if (rst_n && !finished) check_now(mode_tag());

    function automatic logic [W-1:0] rnd_row();
        logic [159:0] t;
        t = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
        return t[W-1:0];
    endfunction

    task automatic step(input logic stb, input logic [W-1:0] d);
        @(posedge clk);
        #2;
        line_strobe = stb;
        row_data = d;
    endtask

    task automatic set_mode(input logic on_f, input logic inv_f, input logic st_f);
        disp_on = on_f; inverse = inv_f; static_drv = st_f;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R1: strobe with data during reset must be ignored.
        line_strobe = 1'b1;
        for (int i = 0; i < 5; i++) step(1'b1, rnd_row());
        step(1'b0, rnd_row());
        rst_n = 1'b1;
        @(negedge clk); check_now("R1 reset clears held row");
        inverse = 1'b1;
        #1 check_now("R1 reset row inverted");
        inverse = 1'b0;

        // R2: capture of distinct patterns.
        step(1'b1, '1);
        step(1'b1, {33{4'hA}});
        step(1'b1, '0);
        step(1'b1, {{(W-1){1'b0}}, 1'b1});
        step(1'b1, {1'b1, {(W-1){1'b0}}});
        for (int i = 0; i < 20; i++) step(1'b1, rnd_row());

        // R3: hold while row_data changes without strobe.
        for (int i = 0; i < 10; i++) step(1'b0, rnd_row());
        step(1'b1, rnd_row());
        for (int i = 0; i < 3; i++) step(1'b0, ~row_data);

        // R4/R5/R6 over all flag combinations with captures in between.
        for (int m = 0; m < 8; m++) begin
            step(1'b1, rnd_row());
            set_mode(m[0], m[1], m[2]);
            for (int k = 0; k < 4; k++) step(k[0], rnd_row());
        end
        set_mode(1'b1, 1'b0, 1'b0);

        // R7: mid-cycle flag changes, then back to normal with the same row.
        step(1'b1, rnd_row());
        step(1'b0, '0);
        @(negedge clk);
        saved = seg_out;
        for (int m = 0; m < 8; m++) begin
            set_mode(m[0], m[1], m[2]);
            #1 check_now("R7 mid-cycle flag change");
        end
        set_mode(1'b1, 1'b0, 1'b0);
        #1;
        n_checks++;
        if (seg_out !== saved) begin
            n_fail++;
            $display("FAIL R7 held row altered actual=%h expected=%h", seg_out, saved);
        end
        for (int i = 0; i < 3; i++) step(1'b0, rnd_row());

        // R1 again: reset mid-run clears the row.
        step(1'b1, rnd_row());
        rst_n = 1'b0;
        step(1'b1, rnd_row());
        step(1'b0, rnd_row());
        rst_n = 1'b1;
        step(1'b0, rnd_row());
        step(1'b0, rnd_row());
        @(negedge clk);
        #1;
        finish_run();
    end
endmodule